// File: doc/BRIEF.md
# AC-link codec frame engine

This block is the codec-side serial engine of an AC'97-style link. It runs on the bit clock that the codec itself drives and follows the SYNC strobe from the link controller. A frame is one 16-bit tag slot followed by twelve 20-bit slots, 256 bit clocks in all. SYNC rises at the start of each frame, stays high through the 16-clock tag phase and is low for the rest of the frame. A rising SYNC always restarts framing.

In the controller-to-codec direction the engine shifts in the frame-valid flag and the per-slot valid tags. It decodes the command address and data slots into single-cycle register writes or pending reads. It also hands the six playback samples (front left, front right, center, left surround, right surround, low-frequency) to parallel ports, each with a one-cycle strobe. In the codec-to-controller direction it builds the tag slot on its own from the codec-ready input, the pending read response and the record-sample valid flag. It then serializes the echoed register index, the read data and the two 16-bit record samples, and every unused or invalid bit goes out as zero.

Bits are launched on the rising edge of the bit clock and captured on the falling edge. The register file, the converters and the sample sources sit outside the block.

Top module: `aclink_codec_engine`

## Requirements
- R1: After SYNC is first seen high on a falling edge, frame bit k is driven on the (k+1)-th following rising edge and sampled on the (k+1)-th following falling edge. Bits go MSB first: the tag slot is bits 0..15 (its bit 15 first), then slots 1..12 with 20 bits each. A SYNC rise restarts the count at bit 0.
- R2: The outgoing tag slot carries codec-ready in bit 15, the slot 1 and slot 2 tags in bits 14 and 13 (set when a read response is sent), the slot 3 and slot 4 tags in bits 12 and 11 (set when record samples are sent), and zeros in bits 10..0.
- R3: In an incoming frame, a register write is issued as exactly one regWrEn pulse, with regWrAddr = slot1[18:12] and regWrData = slot2[19:4], when all of the following hold: the tag slot has bit 15 (frame valid), bit 14 (slot 1) and bit 13 (slot 2) set; slot1[19] = 0 (write); and the index is even.
- R4: No write is issued when any condition of R3 is missing: frame-valid clear, a slot 1 or slot 2 tag clear, slot1[19] = 1, or an odd index.
- R5: A read command needs frame-valid set, the slot 1 tag set and slot1[19] = 1. It is answered in the very next outgoing frame. Slot 1 then carries {0, index, 12 zeros}, slot 2 carries {regRdData at regRdAddr = index, 4 zeros}, and tag bits 14 and 13 are set. Without a read in the previous frame, both slots and both tags are zero.
- R6: When recValid is high at the frame start, slots 3 and 4 carry {recLeft, 4 zeros} and {recRight, 4 zeros}. Otherwise both slots are zero and tag bits 12 and 11 are clear. Record and ready inputs are captured at the SYNC rise.
- R7: Outgoing slots 5 to 12 are always zero.
- R8: Incoming slots 3, 4, 6, 7, 8 and 9 map to pcmSample channels 0 to 5 (front left, front right, center, left surround, right surround, LFE). A channel is loaded with the full 20-bit slot and strobes pcmStb for one cycle only when frame-valid and that slot's tag are set. Otherwise it keeps its value.
- R9: During reset and before the first SYNC rise, serOut, regWrEn, pcmStb and pcmSample are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Frame strobe from controller |
| serIn | input | 1 | Serial data from controller |
| serOut | output | 1 | Serial data to controller |
| codecReady | input | 1 | Codec-ready flag for the tag slot |
| recValid | input | 1 | Record samples valid |
| recLeft | input | 16 | Left record sample |
| recRight | input | 16 | Right record sample |
| regWrEn | output | 1 | Register write strobe |
| regWrAddr | output | 7 | Register write index |
| regWrData | output | 16 | Register write data |
| regRdAddr | output | 7 | Register read index |
| regRdData | input | 16 | Register read data |
| pcmStb | output | 6 | Per-channel sample strobe |
| pcmSample | output | 6x20 | Per-channel playback samples |

## Verification
The bench goes after the write qualifiers one at a time: frame-valid cleared, a missing slot 2 tag, an odd index, a read bit. A decoder that dropped any term would pulse regWrEn and corrupt the model register file. Read responses are checked across three frames, so a response sent one frame late, left stuck, or echoing the wrong index shows up in the slot 1 and slot 2 words. Playback slots are sent with data but with their tags cleared, which exposes a lane that loads without its tag. A one-bit slip in framing moves the codec-ready bit out of position 15 of the tag slot.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  parameter int TAG_W      = 16;
  parameter int SLOT_W     = 20;
  parameter int NUM_SLOTS  = 12;
  parameter int IDX_W      = 7;
  parameter int REG_W      = 16;
  parameter int SMP_W      = 16;
  parameter int NUM_PCM    = 6;
  parameter int SLOT_IDX_W = $clog2(NUM_SLOTS + 1);
  parameter int BIT_POS_W  = $clog2(SLOT_W);

  typedef struct packed {
    logic                  frameStart;
    logic                  sampleEn;
    logic                  slotEnd;
    logic                  active;
    logic [SLOT_IDX_W-1:0] slotIdx;
    logic [BIT_POS_W-1:0]  bitPos;
  } link_strobe_t;

  function automatic int pcmSlotOf(input int ch);
    return (ch < 2) ? ch + 3 : ch + 4;
  endfunction
endpackage

// File: rtl/aclink_ctrl.sv
module aclink_ctrl
  import aclink_pkg::*;
(
  input  logic         bitClk,
  input  logic         rstN,
  input  logic         syncIn,
  output link_strobe_t strobe
);
  localparam logic [SLOT_IDX_W-1:0] LAST_SLOT = SLOT_IDX_W'(NUM_SLOTS);
  localparam logic [BIT_POS_W-1:0]  TAG_LAST  = BIT_POS_W'(TAG_W - 1);
  localparam logic [BIT_POS_W-1:0]  SLOT_LAST = BIT_POS_W'(SLOT_W - 1);

  logic                  syncPrev;
  logic                  active;
  logic [SLOT_IDX_W-1:0] slotIdx;
  logic [BIT_POS_W-1:0]  bitPos;
  logic                  syncRise;
  logic                  atLast;

  assign syncRise = syncIn & ~syncPrev;
  assign atLast   = (slotIdx == '0) ? (bitPos == TAG_LAST) : (bitPos == SLOT_LAST);

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      active   <= 1'b0;
      slotIdx  <= '0;
      bitPos   <= '0;
    end else begin
      syncPrev <= syncIn;
      if (syncRise) begin
        active  <= 1'b1;
        slotIdx <= '0;
        bitPos  <= '0;
      end else if (active) begin
        if (atLast) begin
          bitPos <= '0;
          if (slotIdx == LAST_SLOT) active <= 1'b0;
          else slotIdx <= slotIdx + 1'b1;
        end else begin
          bitPos <= bitPos + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.frameStart = syncRise;
    strobe.sampleEn   = active & ~syncRise;
    strobe.slotEnd    = active & ~syncRise & atLast;
    strobe.active     = active;
    strobe.slotIdx    = slotIdx;
    strobe.bitPos     = bitPos;
  end

  AST_START_ALIGN: assert property (@(negedge bitClk) disable iff (!rstN)
    syncRise |=> (active && slotIdx == '0 && bitPos == '0)); // R1

  AST_POS_BOUND: assert property (@(negedge bitClk) disable iff (!rstN)
    (active && slotIdx == '0) |-> (bitPos <= TAG_LAST)); // R1
endmodule

// File: rtl/aclink_dp.sv
module aclink_dp
  import aclink_pkg::*;
(
  input  logic                            bitClk,
  input  logic                            rstN,
  input  logic                            serIn,
  input  link_strobe_t                    strobe,
  input  logic                            codecReady,
  input  logic                            recValid,
  input  logic [SMP_W-1:0]                recLeft,
  input  logic [SMP_W-1:0]                recRight,
  input  logic [REG_W-1:0]                regRdData,
  output logic                            serOut,
  output logic                            regWrEn,
  output logic [IDX_W-1:0]                regWrAddr,
  output logic [REG_W-1:0]                regWrData,
  output logic [IDX_W-1:0]                regRdAddr,
  output logic [NUM_PCM-1:0]              pcmStb,
  output logic [NUM_PCM-1:0][SLOT_W-1:0]  pcmSample
);
  localparam int IDX_MSB  = SLOT_W - 2;
  localparam int IDX_LSB  = SLOT_W - 1 - IDX_W;
  localparam int DATA_LSB = SLOT_W - REG_W;
  localparam int PAD_W    = SLOT_W - SMP_W;
  localparam int LOW_W    = SLOT_W - 1 - IDX_W;
  localparam int TAG_PAD  = TAG_W - 5;

  logic [SLOT_W-1:0] shiftReg, nextShift;
  logic [TAG_W-1:0]  tagWord;
  logic [SLOT_W-1:0] cmdWord;
  logic              pendValid;
  logic [IDX_W-1:0]  pendIdx;
  logic              rspValid;
  logic [IDX_W-1:0]  rspIdx;
  logic [REG_W-1:0]  rspData;
  logic              readyLat, recLatValid;
  logic [SMP_W-1:0]  recLatL, recLatR;
  logic              frameOk;

  assign nextShift = {shiftReg[SLOT_W-2:0], serIn};
  assign frameOk   = tagWord[TAG_W-1];
  assign regRdAddr = pendIdx;

  // capture, command decode, frame-start staging
  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      tagWord     <= '0;
      cmdWord     <= '0;
      pendValid   <= 1'b0;
      pendIdx     <= '0;
      rspValid    <= 1'b0;
      rspIdx      <= '0;
      rspData     <= '0;
      readyLat    <= 1'b0;
      recLatValid <= 1'b0;
      recLatL     <= '0;
      recLatR     <= '0;
      regWrEn     <= 1'b0;
      regWrAddr   <= '0;
      regWrData   <= '0;
    end else begin
      regWrEn <= 1'b0;
      if (strobe.frameStart) begin
        rspValid    <= pendValid;
        rspIdx      <= pendIdx;
        rspData     <= regRdData;
        pendValid   <= 1'b0;
        readyLat    <= codecReady;
        recLatValid <= recValid;
        recLatL     <= recLeft;
        recLatR     <= recRight;
      end
      if (strobe.sampleEn) shiftReg <= nextShift;
      if (strobe.slotEnd) begin
        case (strobe.slotIdx)
          SLOT_IDX_W'(0): tagWord <= nextShift[TAG_W-1:0];
          SLOT_IDX_W'(1): begin
            cmdWord <= nextShift;
            if (frameOk && tagWord[TAG_W-2] && nextShift[SLOT_W-1]) begin
              pendValid <= 1'b1;
              pendIdx   <= nextShift[IDX_MSB:IDX_LSB];
            end
          end
          SLOT_IDX_W'(2): begin
            if (frameOk && tagWord[TAG_W-2] && tagWord[TAG_W-3] &&
                !cmdWord[SLOT_W-1] && !cmdWord[IDX_LSB]) begin
              regWrEn   <= 1'b1;
              regWrAddr <= cmdWord[IDX_MSB:IDX_LSB];
              regWrData <= nextShift[SLOT_W-1:DATA_LSB];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // playback lanes
  for (genvar g = 0; g < NUM_PCM; g++) begin : gLane
    localparam int LANE_SLOT = pcmSlotOf(g);
    logic [SLOT_W-1:0] laneData;
    logic              laneStb;
    always_ff @(negedge bitClk or negedge rstN) begin
      if (!rstN) begin
        laneData <= '0;
        laneStb  <= 1'b0;
      end else begin
        laneStb <= 1'b0;
        if (strobe.slotEnd && strobe.slotIdx == SLOT_IDX_W'(LANE_SLOT) &&
            frameOk && tagWord[TAG_W-1-LANE_SLOT]) begin
          laneData <= nextShift;
          laneStb  <= 1'b1;
        end
      end
    end
    assign pcmSample[g] = laneData;
    assign pcmStb[g]    = laneStb;
  end

  // serializer
  logic [TAG_W-1:0]  tagIn;
  logic [SLOT_W-1:0] rspAddrWord, rspDataWord, recWordL, recWordR;
  logic [3:0]        tagSel;
  logic [BIT_POS_W-1:0] wordSel;
  logic              txBit;

  assign tagIn       = {readyLat, rspValid, rspValid, recLatValid, recLatValid, {TAG_PAD{1'b0}}};
  assign rspAddrWord = {1'b0, rspIdx, {LOW_W{1'b0}}};
  assign rspDataWord = {rspData, {DATA_LSB{1'b0}}};
  assign recWordL    = {recLatL, {PAD_W{1'b0}}};
  assign recWordR    = {recLatR, {PAD_W{1'b0}}};
  assign tagSel      = 4'(TAG_W - 1) - strobe.bitPos[3:0];
  assign wordSel     = BIT_POS_W'(SLOT_W - 1) - strobe.bitPos;

  always_comb begin
    case (strobe.slotIdx)
      SLOT_IDX_W'(0): txBit = tagIn[tagSel];
      SLOT_IDX_W'(1): txBit = rspValid & rspAddrWord[wordSel];
      SLOT_IDX_W'(2): txBit = rspValid & rspDataWord[wordSel];
      SLOT_IDX_W'(3): txBit = recLatValid & recWordL[wordSel];
      SLOT_IDX_W'(4): txBit = recLatValid & recWordR[wordSel];
      default:        txBit = 1'b0;
    endcase
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) serOut <= 1'b0;
    else       serOut <= strobe.active & txBit;
  end

  AST_WR_SINGLE: assert property (@(negedge bitClk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R3

  AST_WR_EVEN: assert property (@(negedge bitClk) disable iff (!rstN)
    regWrEn |-> !regWrAddr[0]); // R4

  AST_LANE_ONEHOT: assert property (@(negedge bitClk) disable iff (!rstN)
    $onehot0(pcmStb)); // R8

  AST_RSP_GATE: assert property (@(posedge bitClk) disable iff (!rstN)
    (strobe.active && strobe.slotIdx == SLOT_IDX_W'(1) && !rspValid) |=> !serOut); // R5

  AST_REC_GATE: assert property (@(posedge bitClk) disable iff (!rstN)
    (strobe.active && strobe.slotIdx == SLOT_IDX_W'(3) && !recLatValid) |=> !serOut); // R6

  AST_TAIL_ZERO: assert property (@(posedge bitClk) disable iff (!rstN)
    (strobe.active && strobe.slotIdx >= SLOT_IDX_W'(5)) |=> !serOut); // R7
endmodule

// File: rtl/aclink_codec_engine.sv
module aclink_codec_engine
  import aclink_pkg::*;
(
  input  logic                            bitClk,
  input  logic                            rstN,
  input  logic                            syncIn,
  input  logic                            serIn,
  output logic                            serOut,
  input  logic                            codecReady,
  input  logic                            recValid,
  input  logic [SMP_W-1:0]                recLeft,
  input  logic [SMP_W-1:0]                recRight,
  output logic                            regWrEn,
  output logic [IDX_W-1:0]                regWrAddr,
  output logic [REG_W-1:0]                regWrData,
  output logic [IDX_W-1:0]                regRdAddr,
  input  logic [REG_W-1:0]                regRdData,
  output logic [NUM_PCM-1:0]              pcmStb,
  output logic [NUM_PCM-1:0][SLOT_W-1:0]  pcmSample
);
  link_strobe_t strobe;

  aclink_ctrl uCtrl (
    .bitClk (bitClk),
    .rstN   (rstN),
    .syncIn (syncIn),
    .strobe (strobe)
  );

  aclink_dp uDp (
    .bitClk     (bitClk),
    .rstN       (rstN),
    .serIn      (serIn),
    .strobe     (strobe),
    .codecReady (codecReady),
    .recValid   (recValid),
    .recLeft    (recLeft),
    .recRight   (recRight),
    .regRdData  (regRdData),
    .serOut     (serOut),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .regRdAddr  (regRdAddr),
    .pcmStb     (pcmStb),
    .pcmSample  (pcmSample)
  );
endmodule

// File: tb/tb_aclink_codec_engine.sv
module tb_aclink_codec_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, syncIn, serIn, codecReady, recValid;
  logic [15:0] recLeft, recRight;
  logic serOut, regWrEn;
  logic [6:0] regWrAddr, regRdAddr;
  logic [15:0] regWrData, regRdData;
  logic [5:0] pcmStb;
  logic [5:0][19:0] pcmSample;

  aclink_codec_engine dut (
    .bitClk(clk), .rstN(rstN), .syncIn(syncIn), .serIn(serIn), .serOut(serOut),
    .codecReady(codecReady), .recValid(recValid), .recLeft(recLeft), .recRight(recRight),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData), .pcmStb(pcmStb), .pcmSample(pcmSample)
  );

  logic [15:0] regMem [0:127];
  logic [15:0] expReg [0:127];
  assign regRdData = regMem[regRdAddr];

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int wrCount = 0;
  logic [6:0] lastWrAddr;
  logic [15:0] lastWrData;
  logic [19:0] gotPcm [6];
  int stbCnt [6];
  logic [19:0] expPcm [6];
  int expStb [6];

  always @(posedge clk) begin
    if (rstN) begin
      if (regWrEn) begin
        regMem[regWrAddr] = regWrData;
        lastWrAddr = regWrAddr;
        lastWrData = regWrData;
        wrCount++;
      end
      for (int c = 0; c < 6; c++)
        if (pcmStb[c]) begin
          gotPcm[c] = pcmSample[c];
          stbCnt[c]++;
        end
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic int laneSlot(input int ch);
    return (ch < 2) ? ch + 3 : ch + 4;
  endfunction

  logic [19:0] outSlot [13];
  logic [19:0] inSlot [13];

  // stimulus for next frame
  bit fvB;
  logic [12:0] tagsB;
  logic [19:0] s1B, s2B;
  logic [19:0] pcmB [6];
  bit pendPrev = 0;
  logic [6:0] pendIdx = '0;

  task automatic runFrame();
    int pos;
    @(posedge clk); #1 syncIn = 1'b1; serIn = 1'b0;
    for (int s = 0; s < 13; s++) inSlot[s] = '0;
    pos = 0;
    for (int s = 0; s < 13; s++) begin
      for (int b = (s == 0 ? 15 : 19); b >= 0; b--) begin
        if (pos < 255) begin
          @(posedge clk); #1 serIn = outSlot[s][b]; syncIn = (pos < 15);
          @(negedge clk); #1 inSlot[s][b] = serOut;
          pos++;
        end
      end
    end
  endtask

  task automatic doFrame();
    logic [15:0] expTag;
    logic [19:0] expS1, expS2, expS3, expS4, tailOr;
    bit wrExp, rdExp;
    int wrBefore;
    expTag = {codecReady, pendPrev, pendPrev, recValid, recValid, 11'b0};
    expS1 = pendPrev ? {1'b0, pendIdx, 12'h000} : 20'h0;
    expS2 = pendPrev ? {expReg[pendIdx], 4'h0} : 20'h0;
    expS3 = recValid ? {recLeft, 4'h0} : 20'h0;
    expS4 = recValid ? {recRight, 4'h0} : 20'h0;
    wrExp = fvB && tagsB[1] && tagsB[2] && !s1B[19] && !s1B[12];
    rdExp = fvB && tagsB[1] && s1B[19];
    for (int s = 0; s < 13; s++) outSlot[s] = '0;
    outSlot[0][15] = fvB;
    for (int s = 1; s < 13; s++) outSlot[0][15-s] = tagsB[s];
    outSlot[1] = s1B;
    outSlot[2] = s2B;
    for (int c = 0; c < 6; c++) outSlot[laneSlot(c)] = pcmB[c];
    wrBefore = wrCount;
    runFrame();
    check("R2", "tag slot", {16'h0, inSlot[0][15:0]}, {16'h0, expTag});
    check("R5", "slot1 echo", {12'h0, inSlot[1]}, {12'h0, expS1});
    check("R5", "slot2 data", {12'h0, inSlot[2]}, {12'h0, expS2});
    check("R6", "slot3 left", {12'h0, inSlot[3]}, {12'h0, expS3});
    check("R6", "slot4 right", {12'h0, inSlot[4]}, {12'h0, expS4});
    tailOr = '0;
    for (int s = 5; s < 13; s++) tailOr |= inSlot[s];
    check("R7", "slots5-12 or", {12'h0, tailOr}, 32'h0);
    if (wrExp) begin
      check("R3", "write count", wrCount - wrBefore, 1);
      check("R3", "write addr/data", {9'h0, lastWrAddr, lastWrData}, {9'h0, s1B[18:12], s2B[19:4]});
      expReg[s1B[18:12]] = s2B[19:4];
    end else begin
      check("R4", "no write", wrCount - wrBefore, 0);
    end
    pendPrev = rdExp;
    pendIdx = s1B[18:12];
    for (int c = 0; c < 6; c++) begin
      if (fvB && tagsB[laneSlot(c)]) begin
        expPcm[c] = pcmB[c];
        expStb[c]++;
      end
      check("R8", $sformatf("lane%0d sample", c), {12'h0, gotPcm[c]}, {12'h0, expPcm[c]});
      check("R8", $sformatf("lane%0d strobes", c), stbCnt[c], expStb[c]);
    end
  endtask

  task automatic clearCmd();
    fvB = 0; tagsB = '0; s1B = '0; s2B = '0;
    for (int c = 0; c < 6; c++) pcmB[c] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 128; i++) begin regMem[i] = '0; expReg[i] = '0; end
    for (int c = 0; c < 6; c++) begin gotPcm[c] = '0; stbCnt[c] = 0; expPcm[c] = '0; expStb[c] = 0; end
    rstN = 0; syncIn = 0; serIn = 0; codecReady = 0; recValid = 0; recLeft = '0; recRight = '0;
    clearCmd();
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R9", "reset serOut", {31'h0, serOut}, 0);
    check("R9", "reset regWrEn", {31'h0, regWrEn}, 0);
    check("R9", "reset pcmStb", {26'h0, pcmStb}, 0);
    check("R9", "reset lane0", {12'h0, pcmSample[0]}, 0);
    rstN = 1;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1 serIn = i[0];
      @(negedge clk); #1 check("R9", "idle serOut before sync", {31'h0, serOut}, 0);
    end
    serIn = 0;

    // F1: write command without frame valid, nothing else
    clearCmd();
    tagsB[1] = 1; tagsB[2] = 1; s1B = {1'b0, 7'h04, 12'h0}; s2B = {16'h1111, 4'h0};
    doFrame();

    // F2: ready, valid write, all lanes tagged
    codecReady = 1;
    clearCmd();
    fvB = 1; tagsB = 13'b0_0011_1101_1110;
    s1B = {1'b0, 7'h02, 12'h0}; s2B = {16'hBEEF, 4'h0};
    for (int c = 0; c < 6; c++) pcmB[c] = 20'(32'h1000 * (c + 1) + 32'h35);
    doFrame();
    check("R1", "ready bit alone in tag slot", {16'h0, inSlot[0][15:0]}, 32'h8000);

    // F3: odd index write dropped
    clearCmd();
    fvB = 1; tagsB[1] = 1; tagsB[2] = 1; s1B = {1'b0, 7'h03, 12'h0}; s2B = {16'h2222, 4'h0};
    doFrame();

    // F4: slot2 tag missing
    clearCmd();
    fvB = 1; tagsB[1] = 1; s1B = {1'b0, 7'h06, 12'h0}; s2B = {16'h3333, 4'h0};
    doFrame();

    // F5: read of index 02, lanes carry data but untagged
    clearCmd();
    fvB = 1; tagsB[1] = 1; s1B = {1'b1, 7'h02, 12'h0};
    for (int c = 0; c < 6; c++) pcmB[c] = 20'hFFFFF;
    doFrame();

    // F6: response expected here; record samples on
    clearCmd();
    recValid = 1; recLeft = 16'hA5C3; recRight = 16'h0F01;
    doFrame();
    check("R5", "response slot1 directed", {12'h0, inSlot[1]}, {12'h0, 1'b0, 7'h02, 12'h0});
    check("R5", "response slot2 directed", {12'h0, inSlot[2]}, {12'h0, 16'hBEEF, 4'h0});

    // F7: response cleared
    clearCmd();
    recValid = 0;
    doFrame();

    // random frames
    for (int n = 0; n < 48; n++) begin
      clearCmd();
      codecReady = ($urandom % 4) != 0;
      recValid = $urandom % 2;
      recLeft = 16'($urandom); recRight = 16'($urandom);
      fvB = ($urandom % 8) != 0;
      tagsB[1] = ($urandom % 8) != 0;
      tagsB[2] = ($urandom % 8) != 0;
      s1B = {1'($urandom), 7'($urandom % 16), 12'h0};
      s2B = {16'($urandom), 4'h0};
      for (int c = 0; c < 6; c++) begin
        tagsB[laneSlot(c)] = $urandom % 2;
        pcmB[c] = 20'($urandom);
      end
      repeat ($urandom % 3) begin @(posedge clk); #1 syncIn = 0; serIn = 0; end
      doFrame();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule